// File: doc/BRIEF.md
# Low-Activity Sequential Shift-and-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands over a sequence of cycles and returns a 2*WIDTH-bit product. It is arranged to keep switching activity low. The multiplier operand is captured once and never shifted. A one-hot ring counter, as wide as the operand, selects the multiplier bit that is examined in each cycle. The multiplicand drives one adder input directly, with no zero/operand selector in front of it.

The running upper partial product is steered into one of two registers, a feed register or a skip register. The choice depends on the next multiplier bit. When the current bit is zero, the adder inputs do not move and the new upper half is taken from the skip register. Each low product bit is written once, into its own enable-gated cell, in the cycle in which it becomes final. Only the upper half shifts.

A caller pulses `start` with the operands applied while the block is idle. After WIDTH+1 further clock edges, `done` rises for one cycle and `product` holds A*B until the next operation completes.

Top module: `lowact_mult`

## Requirements
- R1: One cycle after `done` is sampled high, `product` equals the unsigned product of the `a` and `b` values present when `start` was accepted. This holds for 0, all-ones, single-bit and arbitrary operands.
- R2: `start` is accepted only in the idle phase. `done` is high at the (WIDTH+1)th rising edge after the accepting edge.
- R3: While an operation is in progress, `start` and changes on `a` or `b` are ignored. The captured operands stay fixed, no extra `done` appears, and the product is that of the accepted operands.
- R4: While computing, the ring counter has exactly one bit set. Bit n is set in the nth compute cycle, counting from 0.
- R5: In a compute cycle whose selected multiplier bit is 0, both adder inputs hold the values they had in the previous cycle. This applies to every cycle except the first.
- R6: Low-half cell n changes only in the cycle in which ring bit n is set, or on load, where all cells are cleared.
- R7: `done` is a single-cycle pulse. `product` keeps its value while the block is idle after completion.
- R8: After reset, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Registered unsigned product |
| done | output | 1 | One-cycle pulse when `product` is updated |

## Verification
Several properties are checked on every clock:
- the ring counter stays one-hot while computing;
- the captured operands do not move once a run has begun;
- the feed register holds still on zero-bit cycles, so the adder sees no new inputs;
- each low cell holds unless its ring bit or the load enables it;
- `done` never lasts two cycles.

Only the bench scenarios show the arithmetic result against A*B. They also show the exact latency, the rejection of `start` pulses and operand changes during a run, and that the product is retained afterwards.

// File: rtl/lowact_mult_pkg.sv
package lowact_mult_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_FIN  = 2'd2
   } phase_e;
endpackage

// File: rtl/lowact_ring.sv
module lowact_ring #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   output logic [WIDTH-1:0] ring
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ring <= '0;
      else if (load)    ring <= WIDTH'(1);
      else if (advance) ring <= {ring[WIDTH-2:0], ring[WIDTH-1]};
   end

   // R4
   ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> ($countones(ring) == 1));
endmodule

// File: rtl/lowact_adder.sv
module lowact_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH:0]   sum
);
   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0]   cy;
      logic [WIDTH-1:0] s;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign s[i]    = x[i] ^ y[i] ^ cy[i];
         assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
      end
      assign sum = {cy[WIDTH], s};
   end else begin : g_infer
      assign sum = {1'b0, x} + {1'b0, y};
   end
endmodule

// File: rtl/lowact_lowbank.sv
module lowact_lowbank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [WIDTH-1:0] en,
   input  logic             d,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= 1'b0;
         else if (clr)   q[i] <= 1'b0;
         else if (en[i]) q[i] <= d;
      end

      // R6
      cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!en[i] && !clr) |=> $stable(q[i]));
   end
endmodule

// File: rtl/lowact_mult.sv
module lowact_mult
   import lowact_mult_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [2*WIDTH-1:0] product,
   output logic               done
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("lowact_mult: WIDTH must be at least 2");
   end

   phase_e           phase_q;
   logic [WIDTH-1:0] a_q, b_q, feed_q, skip_q, hi_q, low_q, ring;
   logic [WIDTH:0]   add_out, src;
   logic [WIDTH-1:0] next_hi;
   logic             load, run, cur_bit, nxt_bit;

   assign load = (phase_q == PH_IDLE) && start;
   assign run  = (phase_q == PH_RUN);

   lowact_ring #(.WIDTH(WIDTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(run), .ring(ring));

   // multiplicand wired straight to the adder; feed register on the other side
   lowact_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x(feed_q), .y(a_q), .sum(add_out));

   assign cur_bit = |(b_q & ring);
   assign nxt_bit = |(b_q & {ring[WIDTH-2:0], 1'b0});
   assign src     = cur_bit ? add_out : {1'b0, skip_q};
   assign next_hi = src[WIDTH:1];

   lowact_lowbank #(.WIDTH(WIDTH)) u_low (
      .clk(clk), .rst_n(rst_n), .clr(load),
      .en(ring & {WIDTH{run}}), .d(src[0]), .q(low_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         a_q     <= '0;
         b_q     <= '0;
         feed_q  <= '0;
         skip_q  <= '0;
         hi_q    <= '0;
         product <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase_q)
            PH_IDLE: if (start) begin
               a_q     <= a;
               b_q     <= b;
               feed_q  <= '0;   // partial product is zero for either look-ahead choice
               skip_q  <= '0;
               hi_q    <= '0;
               phase_q <= PH_RUN;
            end
            PH_RUN: begin
               hi_q <= next_hi;
               if (nxt_bit) feed_q <= next_hi;
               else         skip_q <= next_hi;
               if (ring[WIDTH-1]) phase_q <= PH_FIN;
            end
            PH_FIN: begin
               product <= PW'({hi_q, low_q});
               done    <= 1'b1;
               phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // R3
   operands_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> ($stable(a_q) && $stable(b_q)));

   // R5
   feed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cur_bit && !ring[0]) |-> ($stable(feed_q) && $stable(a_q)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/test_lowact_mult.sv
module test_lowact_mult;
   localparam int W      = 8;
   localparam int PERIOD = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   a_i = '0, b_i = '0;
   logic [2*W-1:0] product;
   logic           done;

   typedef struct {
      logic [2*W-1:0] exp;
      int unsigned    issue;
   } item_t;

   item_t       sb[$];
   int unsigned cyc = 0;
   int          errors = 0, checks = 0;
   string       tag = "R1";
   logic [2*W-1:0] last_exp = '0;

   lowact_mult #(.WIDTH(W)) i_lowact_mult (
      .clk(clk), .rst_n(rst_n), .start(start), .a(a_i), .b(b_i),
      .product(product), .done(done));

   always #(PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [2*W-1:0] act,
                        input logic [2*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check("R3 unexpected done", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check({tag, " product"}, product, it.exp);
            // R2 latency: WIDTH+1 edges after the accepting edge
            check("R2 latency", 2*W'(cyc), 2*W'(it.issue + W + 1));
         end
      end
   end

   task automatic run_op(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input bit intrude);
      item_t it;
      @(negedge clk);
      a_i = av; b_i = bv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      it.exp   = {{W{1'b0}}, av} * {{W{1'b0}}, bv};
      it.issue = cyc;
      last_exp = it.exp;
      sb.push_back(it);
      if (intrude) begin
         @(negedge clk);
         a_i = ~av; b_i = bv ^ 8'h5A; start = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
      end
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset product", product, '0);
      check("R8 reset done", {15'b0, done}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      tag = "R1 zero";
      run_op(8'h00, 8'h00, 0);
      run_op(8'h00, 8'hFF, 0);
      run_op(8'hFF, 8'h00, 0);
      tag = "R5 all-ones";
      run_op(8'hFF, 8'hFF, 0);
      tag = "R4 R6 single-bit";
      for (int i = 0; i < W; i++) run_op(8'hFF, 8'(1 << i), 0);
      for (int i = 0; i < W; i++) run_op(8'(1 << i), 8'hB7, 0);
      tag = "R5 alternating";
      run_op(8'hAA, 8'h55, 0);
      run_op(8'h55, 8'hAA, 0);
      run_op(8'h81, 8'h81, 0);

      tag = "R7 hold";
      run_op(8'hC3, 8'h9E, 0);
      repeat (3) @(negedge clk);
      check("R7 product held", product, last_exp);
      check("R7 done low", {15'b0, done}, '0);

      tag = "R3 busy start";
      run_op(8'h37, 8'hE9, 1);
      run_op(8'hFE, 8'h02, 1);

      tag = "R1 random";
      for (int i = 0; i < 40; i++) run_op(8'($urandom), 8'($urandom), 0);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule